// File: doc/BRIEF.md
# NAND Flash Host Interface

This block sits between a processor's register bus and an 8-bit NAND flash device. Software programs the strobe timing in a control word. It then pushes command bytes, address bytes, write bytes and read requests through four write-only ports. Every push lands in a small queue, and a sequencer drains that queue as NAND bus cycles. A command cycle raises CLE and an address cycle raises ALE. A write cycle drives the data lines with neither raised. A read cycle pulses the read strobe and captures the byte the device returns.

A read takes two steps. The host posts a request through the read-request port. Later the captured byte appears behind the read-data port and an interrupt flag reports it ready. A synchronized copy of the device's ready/busy pin appears in status, and no new bus cycle starts while the device is busy. Five sticky interrupt flags are cleared by writing one, and they are combined with a mask into a single interrupt line.

Register word offsets: 0 control, 1 status, 2 interrupt flags, 3 interrupt mask, 4 command port, 5 address port, 6 write-data port, 7 read-request port, 8 read-data port.

Top module: `nand_host_if`

## Requirements
- R1: The control word (offset 0) holds the write strobe delay in bits 3:0, the read strobe delay in bits 7:4, the data-width select in bit 8 and the page-size select in bit 9. It resets to 0, reads back what was written, and bits 15:10 read as 0.
- R2: Status (offset 1) reads not-busy in bit 0, queue full in bit 1, page write pending in bit 2, page read pending in bit 3 and queue empty in bit 4. With the ready pin high, it reads 0x11 after reset.
- R3: The queue holds 4 entries. A push to offsets 4 to 7 while the queue is full is dropped and sets interrupt flag bit 1.
- R4: Entries leave the queue in push order. Offset 4 produces a cycle with CLE high, offset 5 a cycle with ALE high, and offset 6 a cycle with neither; each drives its byte on the data lines. Only one strobe is low at a time.
- R5: A write strobe stays low for write-delay+1 clocks and a read strobe for read-delay+1 clocks. The delay is taken from the control word when the cycle starts.
- R6: At least one idle clock separates two bus cycles, and exactly one when the next entry is already waiting.
- R7: A write to offset 7 queues a read cycle. The byte on the data inputs at the end of the strobe is captured, interrupt flag bit 3 is set, and offset 8 returns the byte in bits 7:0.
- R8: Status bit 0 follows the ready/busy input after two clocks of synchronization. No bus cycle starts while the synchronized input is low. A low-to-high change sets interrupt flag bit 0.
- R9: Writing to the interrupt flags (offset 2) clears exactly the bits written as 1 and leaves the others.
- R10: The interrupt output is high when any interrupt flag is set whose bit is also set in the mask (offset 3).
- R11: Status bit 2 is high while any write-data entry is queued or in progress. When the last such cycle ends, interrupt flag bit 4 is set, and when the queue becomes empty, interrupt flag bit 2 is set.
- R12: Status bit 3 is high while any read request is queued or in progress, and it clears once the byte is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Register access select |
| hwr | input | 1 | Write when high together with hsel |
| haddr | input | 4 | Register word offset |
| hwdata | input | 16 | Write data |
| hrdata | output | 16 | Read data for haddr, combinational |
| irq | output | 1 | Masked interrupt |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Data to the device |
| nf_dq_oe | output | 1 | Data output enable |
| nf_dq_in | input | 8 | Data from the device |
| nf_rb | input | 1 | Device ready (high) or busy (low) |

## Verification
The bench pushes a fifth entry into a queue held full by a busy device. A design that kept the entry would emit a fifth bus cycle, and one that did not flag the drop would leave flag bit 1 clear. Back-to-back pushes show whether the gap between cycles is exactly one clock; an off-by-one sequencer shows a gap of zero or two, or a strobe of the wrong width. A randomized mix of all four entry kinds under random delays exposes reordering, a swapped CLE/ALE, or a read byte sampled before the end of the strobe. A write-one-to-clear of a single bit, checked against the others, catches a register that clears everything.

// File: rtl/nhi_pkg.sv
`timescale 1ns/1ps
package nhi_pkg;

  typedef enum logic [1:0] {
    ENT_CMD   = 2'd0,
    ENT_ADDR  = 2'd1,
    ENT_WDATA = 2'd2,
    ENT_RDREQ = 2'd3
  } ent_kind_e;

  typedef struct packed {
    ent_kind_e  kind;
    logic [7:0] data;
  } wb_entry_t;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_STROBE = 1'b1} seq_state_e;

  localparam logic [3:0] OFS_CTRL   = 4'd0;
  localparam logic [3:0] OFS_STAT   = 4'd1;
  localparam logic [3:0] OFS_IFLAG  = 4'd2;
  localparam logic [3:0] OFS_IMASK  = 4'd3;
  localparam logic [3:0] OFS_CMD    = 4'd4;
  localparam logic [3:0] OFS_ADDR   = 4'd5;
  localparam logic [3:0] OFS_WDATA  = 4'd6;
  localparam logic [3:0] OFS_RDREQ  = 4'd7;
  localparam logic [3:0] OFS_RDDATA = 4'd8;

  localparam int CTRL_W = 10;
  localparam int FLAG_W = 5;

  // strobe counter load: low time is load+1 clocks
  function automatic logic [3:0] dly_load(ent_kind_e k, logic [3:0] wr_d, logic [3:0] rd_d);
    return (k == ENT_RDREQ) ? rd_d : wr_d;
  endfunction

  function automatic ent_kind_e kind_of_ofs(logic [3:0] ofs);
    return ent_kind_e'(ofs[1:0]);
  endfunction

  function automatic logic is_queue_ofs(logic [3:0] ofs);
    return (ofs >= OFS_CMD) && (ofs <= OFS_RDREQ);
  endfunction

  function automatic logic [FLAG_W-1:0] pack_status(logic nbusy, logic full, logic wr_p,
                                                     logic rd_p, logic empty);
    return {empty, rd_p, wr_p, full, nbusy};
  endfunction

  function automatic logic [FLAG_W-1:0] w1c_merge(logic [FLAG_W-1:0] cur, logic [FLAG_W-1:0] clr,
                                                   logic [FLAG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/nhi_wbuf.sv
`timescale 1ns/1ps
module nhi_wbuf
  import nhi_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t push_ent,
  input  logic      pop,
  output wb_entry_t head,
  output logic      empty,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wb_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= ptr_inc(wp);
      if (pop)  rp <= ptr_inc(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/nhi_seq.sv
`timescale 1ns/1ps
module nhi_seq
  import nhi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ent_avail,
  input  wb_entry_t  head,
  input  logic       rb_ok,
  input  logic [3:0] wr_dly,
  input  logic [3:0] rd_dly,
  input  logic [7:0] dq_in,
  output logic       pop,
  output logic       done_evt,
  output ent_kind_e  done_kind,
  output logic       cap_evt,
  output logic [7:0] cap_data,
  output logic       nf_cle,
  output logic       nf_ale,
  output logic       nf_we_n,
  output logic       nf_re_n,
  output logic [7:0] nf_dq_out,
  output logic       nf_dq_oe
);
  seq_state_e st;
  logic [3:0] cnt;
  wb_entry_t  cur;
  logic       in_strobe, is_rd;

  // a strobe ends on the edge that returns to idle, so the next pop is one clock later
  assign pop       = (st == SEQ_IDLE) && ent_avail && rb_ok;
  assign in_strobe = (st == SEQ_STROBE);
  assign is_rd     = (cur.kind == ENT_RDREQ);
  assign done_evt  = in_strobe && (cnt == 4'd0);
  assign done_kind = cur.kind;
  assign cap_evt   = done_evt && is_rd;
  assign cap_data  = dq_in;

  assign nf_we_n   = !(in_strobe && !is_rd);
  assign nf_re_n   = !(in_strobe && is_rd);
  assign nf_cle    = in_strobe && (cur.kind == ENT_CMD);
  assign nf_ale    = in_strobe && (cur.kind == ENT_ADDR);
  assign nf_dq_oe  = in_strobe && !is_rd;
  assign nf_dq_out = nf_dq_oe ? cur.data : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SEQ_IDLE;
      cnt <= '0;
      cur <= '0;
    end else if (pop) begin
      st  <= SEQ_STROBE;
      cur <= head;
      cnt <= dly_load(head.kind, wr_dly, rd_dly);
    end else if (in_strobe) begin
      if (cnt == 4'd0) st <= SEQ_IDLE;
      else             cnt <= cnt - 4'd1;
    end
  end
endmodule

// File: rtl/nhi_track.sv
`timescale 1ns/1ps
module nhi_track
  import nhi_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  ent_kind_e push_kind,
  input  logic      done_evt,
  input  ent_kind_e done_kind,
  input  logic      wb_empty,
  output logic      wr_pend,
  output logic      rd_pend,
  output logic      wb_drain,
  output logic      pg_wr_done
);
  localparam int PCNT_W = $clog2(DEPTH + 2);

  logic [PCNT_W-1:0] wr_cnt, rd_cnt;
  logic              wr_in, wr_out, rd_in, rd_out, empty_q;

  function automatic logic [PCNT_W-1:0] step(logic [PCNT_W-1:0] c, logic inc, logic dec);
    return c + PCNT_W'(inc) - PCNT_W'(dec);
  endfunction

  assign wr_in  = push && (push_kind == ENT_WDATA);
  assign wr_out = done_evt && (done_kind == ENT_WDATA);
  assign rd_in  = push && (push_kind == ENT_RDREQ);
  assign rd_out = done_evt && (done_kind == ENT_RDREQ);

  assign wr_pend    = (wr_cnt != '0);
  assign rd_pend    = (rd_cnt != '0);
  assign pg_wr_done = wr_out && !wr_in && (wr_cnt == PCNT_W'(1));
  assign wb_drain   = wb_empty && !empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      empty_q <= 1'b1;
    end else begin
      wr_cnt  <= step(wr_cnt, wr_in, wr_out);
      rd_cnt  <= step(rd_cnt, rd_in, rd_out);
      empty_q <= wb_empty;
    end
  end
endmodule

// File: rtl/nhi_regs.sv
`timescale 1ns/1ps
module nhi_regs
  import nhi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hwr,
  input  logic [3:0]        haddr,
  input  logic [15:0]       hwdata,
  output logic [15:0]       hrdata,
  input  logic              wb_full,
  input  logic              wb_empty,
  input  logic              wr_pend,
  input  logic              rd_pend,
  input  logic              rb_ok,
  input  logic              nb_rise,
  input  logic              wb_drain,
  input  logic              pg_wr_done,
  input  logic              cap_evt,
  input  logic [7:0]        cap_data,
  output logic              push,
  output wb_entry_t         push_ent,
  output logic              push_req,
  output logic              ovf_evt,
  output logic [3:0]        wr_dly,
  output logic [3:0]        rd_dly,
  output logic [FLAG_W-1:0] iflag,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [FLAG_W-1:0] imask, flag_set, flag_clr;
  logic [7:0]        rd_byte;
  logic              wr_en;
  logic              unused_hi;

  assign unused_hi = ^hwdata[15:CTRL_W];
  assign wr_en     = hsel && hwr;
  assign push_req  = wr_en && is_queue_ofs(haddr);
  assign push      = push_req && !wb_full;
  assign ovf_evt   = push_req && wb_full;
  assign push_ent  = '{kind: kind_of_ofs(haddr), data: hwdata[7:0]};

  assign wr_dly = ctrl[3:0];
  assign rd_dly = ctrl[7:4];

  assign flag_set = {pg_wr_done, cap_evt, wb_drain, ovf_evt, nb_rise};
  assign flag_clr = (wr_en && haddr == OFS_IFLAG) ? hwdata[FLAG_W-1:0] : '0;
  assign irq      = |(iflag & imask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      imask   <= '0;
      iflag   <= '0;
      rd_byte <= '0;
    end else begin
      if (wr_en && haddr == OFS_CTRL)  ctrl  <= hwdata[CTRL_W-1:0];
      if (wr_en && haddr == OFS_IMASK) imask <= hwdata[FLAG_W-1:0];
      if (cap_evt) rd_byte <= cap_data;
      iflag <= w1c_merge(iflag, flag_clr, flag_set);
    end
  end

  always_comb begin
    hrdata = '0;
    case (haddr)
      OFS_CTRL:   hrdata[CTRL_W-1:0] = ctrl;
      OFS_STAT:   hrdata[FLAG_W-1:0] = pack_status(rb_ok, wb_full, wr_pend, rd_pend, wb_empty);
      OFS_IFLAG:  hrdata[FLAG_W-1:0] = iflag;
      OFS_IMASK:  hrdata[FLAG_W-1:0] = imask;
      OFS_RDDATA: hrdata[7:0]        = rd_byte;
      default:    hrdata             = '0;
    endcase
  end
endmodule

// File: rtl/nand_host_if.sv
`timescale 1ns/1ps
module nand_host_if
  import nhi_pkg::*;
#(
  parameter int WB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hsel,
  input  logic        hwr,
  input  logic [3:0]  haddr,
  input  logic [15:0] hwdata,
  output logic [15:0] hrdata,
  output logic        irq,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dq_out,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_in,
  input  logic        nf_rb
);
  wb_entry_t         push_ent, head;
  ent_kind_e         done_kind;
  logic              push, push_req, pop, wb_empty, wb_full, ovf_evt;
  logic              done_evt, cap_evt, wr_pend, rd_pend, wb_drain, pg_wr_done;
  logic [7:0]        cap_data;
  logic [3:0]        wr_dly, rd_dly;
  logic [FLAG_W-1:0] iflag;
  logic              rb_s1, rb_ok, rb_prev, nb_rise;

  // two-flop synchronizer, reset to ready so reset release is not a rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1   <= 1'b1;
      rb_ok   <= 1'b1;
      rb_prev <= 1'b1;
    end else begin
      rb_s1   <= nf_rb;
      rb_ok   <= rb_s1;
      rb_prev <= rb_ok;
    end
  end
  assign nb_rise = rb_ok && !rb_prev;

  nhi_regs u_regs (
    .clk, .rst_n, .hsel, .hwr, .haddr, .hwdata, .hrdata,
    .wb_full, .wb_empty, .wr_pend, .rd_pend, .rb_ok, .nb_rise,
    .wb_drain, .pg_wr_done, .cap_evt, .cap_data,
    .push, .push_ent, .push_req, .ovf_evt, .wr_dly, .rd_dly, .iflag, .irq
  );

  nhi_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk, .rst_n, .push, .push_ent, .pop, .head,
    .empty(wb_empty), .full(wb_full)
  );

  nhi_seq u_seq (
    .clk, .rst_n, .ent_avail(!wb_empty), .head, .rb_ok, .wr_dly, .rd_dly,
    .dq_in(nf_dq_in), .pop, .done_evt, .done_kind, .cap_evt, .cap_data,
    .nf_cle, .nf_ale, .nf_we_n, .nf_re_n, .nf_dq_out, .nf_dq_oe
  );

  nhi_track #(.DEPTH(WB_DEPTH)) u_track (
    .clk, .rst_n, .push, .push_kind(push_ent.kind), .done_evt, .done_kind,
    .wb_empty, .wr_pend, .rd_pend, .wb_drain, .pg_wr_done
  );
endmodule

// File: rtl/nhi_checker.sv
`timescale 1ns/1ps
module nhi_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       rb_ok,
  input logic       push_req,
  input logic       wb_full,
  input logic       cap_evt,
  input logic [4:0] iflag
);
  logic [4:0] low_cnt;
  logic       strobe_low;

  assign strobe_low = !nf_we_n || !nf_re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (strobe_low) low_cnt <= (low_cnt == 5'd31) ? low_cnt : low_cnt + 5'd1;
    else                 low_cnt <= '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n) && !(nf_cle && nf_ale));                          // R4
  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= 5'd16);                                                        // R5
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nf_we_n) || $fell(nf_re_n)) |-> ($past(nf_we_n) && $past(nf_re_n))); // R6
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nf_we_n) || $fell(nf_re_n)) |-> $past(rb_ok));                     // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && wb_full) |=> iflag[1]);                                      // R3
  AST_READ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> iflag[3]);                                                    // R7
endmodule

bind nand_host_if nhi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
  .nf_cle(nf_cle), .nf_ale(nf_ale), .rb_ok(rb_ok), .push_req(push_req),
  .wb_full(wb_full), .cap_evt(cap_evt), .iflag(iflag)
);

// File: tb/tb_nand_host_if.sv
`timescale 1ns/1ps
module tb_nand_host_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0, hwr = 1'b0;
  logic [3:0]  haddr = 4'd0;
  logic [15:0] hwdata = 16'd0;
  logic [15:0] hrdata;
  logic        irq, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]  nf_dq_out, nf_dq_in;
  logic        nf_rb = 1'b1;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 1'b0;

  // bus cycle log filled by the monitor: kind 0 cmd, 1 addr, 2 wdata, 3 read
  int log_kind [256];
  int log_data [256];
  int log_width[256];
  int log_gap  [256];
  int log_n = 0;
  int run = 0, idle = 99, cur_kind = 0, cur_data = 0, cur_gap = 0;
  int rd_idx = 0, rd_issued = 0;

  int exp_k[16];
  int exp_d[16];

  always #2.5 clk = ~clk;

  nand_host_if dut (
    .clk, .rst_n, .hsel, .hwr, .haddr, .hwdata, .hrdata, .irq,
    .nf_cle, .nf_ale, .nf_we_n, .nf_re_n, .nf_dq_out, .nf_dq_oe, .nf_dq_in, .nf_rb
  );

  function automatic logic [7:0] rd_value(int i);
    return 8'(32'hA5 ^ (i * 37));
  endfunction

  function automatic int width_of(int kind, int ctrl);
    return (kind == 3) ? ((ctrl >> 4) & 15) + 1 : (ctrl & 15) + 1;
  endfunction

  assign nf_dq_in = rd_value(rd_idx);

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nf_we_n || !nf_re_n) begin
        if (run == 0) begin
          cur_gap  = idle;
          idle     = 0;
          cur_kind = !nf_re_n ? 3 : (nf_cle ? 0 : (nf_ale ? 1 : 2));
          cur_data = !nf_re_n ? int'(nf_dq_in) : int'(nf_dq_out);
        end
        run++;
      end else begin
        if (run > 0) begin
          if (log_n < 256) begin
            log_kind[log_n]  = cur_kind;
            log_data[log_n]  = cur_data;
            log_width[log_n] = run;
            log_gap[log_n]   = cur_gap;
          end
          log_n++;
          if (cur_kind == 3) rd_idx++;
          run = 0;
        end
        idle++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    hsel = 1'b1; hwr = 1'b1; haddr = a; hwdata = d;
    @(negedge clk);
    hsel = 1'b0; hwr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, output int v);
    @(negedge clk);
    haddr = a; hsel = 1'b0; hwr = 1'b0;
    #1 v = int'(hrdata);
  endtask

  task automatic wait_log(input int n);
    while (log_n < n) @(negedge clk);
  endtask

  task automatic wait_not_full();
    int s;
    hr(4'd1, s);
    while ((s & 2) != 0) hr(4'd1, s);
  endtask

  task automatic push_kind(input int k, input int d);
    hw(4'(4 + k), 16'(d));
    if (k == 3) rd_issued++;
  endtask

  initial begin
    int v, base, ctrl, n, st;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    hr(4'd0, v); chk(v == 0, "R1 ctrl reset", v, 0);
    hr(4'd1, v); chk(v == 'h11, "R2 status reset", v, 'h11);
    hr(4'd2, v); chk(v == 0, "R9 flags reset", v, 0);
    chk(irq == 1'b0, "R10 irq reset", int'(irq), 0);

    // control word fields and unused upper bits
    hw(4'd0, 16'hFFFF);
    hr(4'd0, v); chk(v == 'h3FF, "R1 ctrl readback", v, 'h3FF);
    ctrl = 'h32;
    hw(4'd0, 16'(ctrl));

    // back-to-back burst
    base = log_n;
    push_kind(0, 'h90); push_kind(1, 'h00); push_kind(2, 'h11); push_kind(2, 'h22);
    wait_log(base + 4);
    chk(log_kind[base] == 0 && log_data[base] == 'h90, "R4 cmd cycle", log_data[base], 'h90);
    chk(log_kind[base+1] == 1 && log_data[base+1] == 0, "R4 addr cycle", log_kind[base+1], 1);
    chk(log_kind[base+2] == 2 && log_data[base+3] == 'h22, "R4 data order", log_data[base+3], 'h22);
    for (int i = 0; i < 4; i++)
      chk(log_width[base+i] == 3, "R5 write strobe width", log_width[base+i], 3);
    for (int i = 1; i < 4; i++)
      chk(log_gap[base+i] == 1, "R6 single idle clock", log_gap[base+i], 1);
    repeat (6) @(negedge clk);

    // busy device: stall, pending flags, overflow
    nf_rb = 1'b0;
    repeat (3) @(negedge clk);
    hr(4'd1, v); chk((v & 1) == 0, "R8 not-busy follows pin low", v & 1, 0);
    hw(4'd2, 16'h001F);
    base = log_n;
    push_kind(2, 'h33); push_kind(3, 0);
    hr(4'd1, v);
    chk((v & 4) != 0, "R11 page write pending", v, v | 4);
    chk((v & 8) != 0, "R12 page read pending", v, v | 8);
    push_kind(0, 'h70); push_kind(0, 'h71);
    hr(4'd1, v); chk((v & 'h12) == 'h02, "R2 full flag", v & 'h12, 2);
    hr(4'd2, v); chk((v & 2) == 0, "R3 no overflow yet", v & 2, 0);
    hw(4'd4, 16'h00EE);
    hr(4'd2, v); chk((v & 2) != 0, "R3 overflow flag", v & 2, 2);
    repeat (10) @(negedge clk);
    chk(log_n == base, "R8 no cycle while busy", log_n, base);
    nf_rb = 1'b1;
    repeat (3) @(negedge clk);
    hr(4'd1, v); chk((v & 1) == 1, "R8 not-busy follows pin high", v & 1, 1);
    hr(4'd2, v); chk((v & 1) == 1, "R8 ready rising flag", v & 1, 1);
    wait_log(base + 4);
    repeat (30) @(negedge clk);
    chk(log_n == base + 4, "R3 dropped entry not issued", log_n, base + 4);
    chk(log_kind[base] == 2 && log_data[base] == 'h33, "R4 wdata cycle", log_data[base], 'h33);
    chk(log_kind[base+1] == 3, "R7 read cycle issued", log_kind[base+1], 3);
    chk(log_width[base+1] == 4, "R5 read strobe width", log_width[base+1], 4);
    chk(log_data[base+3] == 'h71, "R3 last kept entry", log_data[base+3], 'h71);
    hr(4'd2, v);
    chk((v & 8) != 0, "R7 read ready flag", v, v | 8);
    chk((v & 'h14) == 'h14, "R11 write done and drain flags", v & 'h14, 'h14);
    hr(4'd8, v);
    chk(v == int'(rd_value(rd_issued - 1)), "R7 read data", v, int'(rd_value(rd_issued - 1)));
    hr(4'd1, v); chk((v & 'h1C) == 'h10, "R12 pending clear when idle", v & 'h1C, 'h10);

    // write-one-to-clear and interrupt mask
    hr(4'd2, st);
    hw(4'd2, 16'h0008);
    hr(4'd2, v); chk(v == (st & ~8), "R9 clear one bit", v, st & ~8);
    hw(4'd3, 16'h0008);
    @(negedge clk); chk(irq == 1'b0, "R10 masked-off flag", int'(irq), 0);
    hw(4'd3, 16'h0010);
    @(negedge clk); chk(irq == 1'b1, "R10 enabled flag", int'(irq), 1);
    hw(4'd2, 16'h001F);
    @(negedge clk); chk(irq == 1'b0, "R10 after clear", int'(irq), 0);

    // randomized rounds
    for (int r = 0; r < 8; r++) begin
      ctrl = int'($urandom % 256);
      hw(4'd0, 16'(ctrl));
      n = 1 + int'($urandom % 12);
      base = log_n;
      for (int i = 0; i < n; i++) begin
        exp_k[i] = int'($urandom % 4);
        exp_d[i] = int'($urandom % 256);
        if (exp_k[i] == 3) exp_d[i] = int'(rd_value(rd_issued));
        wait_not_full();
        push_kind(exp_k[i], exp_d[i]);
      end
      wait_log(base + n);
      repeat (20) @(negedge clk);
      for (int i = 0; i < n; i++) begin
        chk(log_kind[base+i] == exp_k[i], "R4 random kind order", log_kind[base+i], exp_k[i]);
        chk(log_data[base+i] == exp_d[i], "R7 random byte", log_data[base+i], exp_d[i]);
        chk(log_width[base+i] == width_of(exp_k[i], ctrl), "R5 random width",
            log_width[base+i], width_of(exp_k[i], ctrl));
        chk(log_gap[base+i] >= 1, "R6 random gap", log_gap[base+i], 1);
      end
      chk(log_n == base + n, "R4 random count", log_n, base + n);
      if (rd_issued > 0) begin
        hr(4'd8, v);
        chk(v == int'(rd_value(rd_issued - 1)), "R7 random read data", v, int'(rd_value(rd_issued - 1)));
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule